// File: doc/BRIEF.md
# Program/Erase Status Polling Logic

This block forms the byte that a flash-style memory returns on a host read while an embedded program or erase operation runs, and it reports when that operation has finished. The command sequencer pulses a start strobe when it begins an operation (after the second write strobe of the command pair). The strobe carries the kind of operation and bit 7 of the byte being written. The sequencer then holds `busy_in` high until the operation ends and raises `fail_in` if it ends badly.

While an operation is in progress, each read strobe yields a status byte in which only two lanes are driven. The toggle lane inverts from one read to the next, and reads with no time between them toggle just the same, because the lane advances per access and not per clock. The polling lane carries the inverse of the written bit 7 for a program and a 0 for an erase. The remaining lanes have their enables low. Once the operation completes cleanly, a one-cycle `done_out` pulse is raised and reads return the array byte on all lanes again. A failed operation keeps the status view until an abort is signalled.

Top module: `stat_poll`

## Requirements
- R1: While `rst_n` is low and after its release, `dq_out`, `dq_oe` and `done_out` are all zero.
- R2: The first read after `op_start` returns 0 on the toggle lane (bit 6). Each later read during the same operation returns the inverse of the read before it.
- R3: The toggle lane advances only on reads. Any number of idle cycles between two reads leaves the alternation unchanged.
- R4: During a program (`op_kind` = 0), bit 7 of a status read is the inverse of the `wr_msb` value latched at `op_start`.
- R5: During an erase (`op_kind` = 1), bit 7 of a status read is 0.
- R6: A status read drives `dq_oe` = 8'hC0 (only bits 7 and 6 enabled). Bits 5 to 0 of `dq_out` read 0.
- R7: When `busy_in` falls with `fail_in` low, `done_out` is high for exactly the next cycle. Reads after that return `array_data` with `dq_oe` = 8'hFF, so bit 6 is stable over two consecutive reads of the same byte.
- R8: When `busy_in` falls with `fail_in` high, no `done_out` pulse occurs. Reads keep the toggling status and the in-progress bit 7 until `abort_in` is pulsed. After the abort, reads return `array_data`.
- R9: The read result appears in the cycle after `rd_strobe`. It holds, with the same enables, until the next read.
- R10: Outside any operation, a read returns `array_data` on all lanes with `dq_oe` = 8'hFF.
- R11: A new `op_start` clears the toggle lane, even when the previous operation left it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse: embedded operation begins |
| op_kind | input | 1 | 0 = program, 1 = erase; sampled with `op_start` |
| wr_msb | input | 1 | Bit 7 of the byte being programmed; sampled with `op_start` |
| busy_in | input | 1 | Sequencer busy flag |
| fail_in | input | 1 | Sequencer failure flag, sampled when `busy_in` falls |
| abort_in | input | 1 | One-cycle pulse: reset sequence received |
| rd_strobe | input | 1 | One-cycle read access |
| array_data | input | 8 | Byte read from the array for the current address |
| dq_out | output | 8 | Returned byte |
| dq_oe | output | 8 | Per-lane output enable |
| done_out | output | 1 | One-cycle end-of-operation pulse |

## Verification
Each read result is due exactly one cycle after its `rd_strobe` edge. The bench drives every input on the falling edge and checks the result at the following falling edge. It then checks again after 0 to 2 idle cycles to confirm that the value holds and that the alternation has not drifted. `done_out` is due in the cycle after the edge that samples `busy_in` low, and it must be gone one cycle later. The bench checks both of those cycles. The sweep covers both operation kinds, both written bit-7 values, one to four status reads, and clean and failed endings. Each expected byte comes from the read count and the scenario index, not from the design.

// File: rtl/stat_poll_pkg.sv
package stat_poll_pkg;

   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } op_kind_e;

   function automatic logic poll_level(input op_kind_e kind, input logic msb);
      return (kind == OP_ERASE) ? 1'b0 : ~msb;
   endfunction

endpackage

// File: rtl/stat_poll_track.sv
module stat_poll_track
   import stat_poll_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  logic     kind_i,
   input  logic     msb_i,
   input  logic     busy_i,
   input  logic     fail_i,
   input  logic     abort_i,
   output logic     active_o,
   output op_kind_e kind_o,
   output logic     msb_o,
   output logic     done_o
);

   logic     busy_q;
   logic     act_q;
   op_kind_e kind_q;
   logic     msb_q;
   logic     done_q;
   logic     busy_fell;

   assign busy_fell = busy_q && !busy_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         act_q  <= 1'b0;
         kind_q <= OP_PROG;
         msb_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         busy_q <= busy_i;
         done_q <= 1'b0;
         if (start_i) begin
            act_q  <= 1'b1;
            kind_q <= op_kind_e'(kind_i);
            msb_q  <= msb_i;
         end else if (abort_i) begin
            act_q <= 1'b0;
         end else if (act_q && busy_fell && !fail_i) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign active_o = act_q;
   assign kind_o   = kind_q;
   assign msb_o    = msb_q;
   assign done_o   = done_q;

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7
   done_leaves_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !act_q);

   // R8
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q && busy_fell && fail_i && !abort_i |=> act_q && !done_q);

endmodule

// File: rtl/stat_poll_toggle.sv
module stat_poll_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic tgl_o
);

   logic tgl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       tgl_q <= 1'b0;
      else if (clear_i) tgl_q <= 1'b0;
      else if (step_i)  tgl_q <= ~tgl_q;
   end

   assign tgl_o = tgl_q;

   // R11
   tgl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !tgl_q);

   // R3
   tgl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i && !step_i |=> tgl_q == $past(tgl_q));

endmodule

// File: rtl/stat_poll_mux.sv
module stat_poll_mux #(
   parameter int DATA_W   = 8,
   parameter int TGL_BIT  = 6,
   parameter int POLL_BIT = 7,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic              status_i,
   input  logic              tgl_i,
   input  logic              poll_i,
   input  logic [DATA_W-1:0] arr_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [DATA_W-1:0] oe_o
);

   logic [DATA_W-1:0] word_n;
   logic [DATA_W-1:0] oe_n;

   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      if (b == TGL_BIT) begin : g_tgl
         assign word_n[b] = status_i ? tgl_i : arr_i[b];
         assign oe_n[b]   = 1'b1;
      end else if (b == POLL_BIT) begin : g_poll
         assign word_n[b] = status_i ? poll_i : arr_i[b];
         assign oe_n[b]   = 1'b1;
      end else begin : g_plain
         assign word_n[b] = status_i ? 1'b0 : arr_i[b];
         assign oe_n[b]   = ~status_i;
      end
   end

   if (REG_OUT) begin : g_reg
      logic [DATA_W-1:0] dq_q;
      logic [DATA_W-1:0] oe_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dq_q <= '0;
            oe_q <= '0;
         end else if (rd_i) begin
            dq_q <= word_n;
            oe_q <= oe_n;
         end
      end

      assign dq_o = dq_q;
      assign oe_o = oe_q;

      // R9
      out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_i |=> $stable(dq_o) && $stable(oe_o));
   end else begin : g_comb
      assign dq_o = rd_i ? word_n : '0;
      assign oe_o = rd_i ? oe_n   : '0;
   end

endmodule

// File: rtl/stat_poll.sv
module stat_poll
   import stat_poll_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int TGL_BIT  = 6,
   parameter int POLL_BIT = 7,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_kind,
   input  logic              wr_msb,
   input  logic              busy_in,
   input  logic              fail_in,
   input  logic              abort_in,
   input  logic              rd_strobe,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe,
   output logic              done_out
);

   localparam logic [DATA_W-1:0] STAT_MASK =
      (DATA_W'(1) << TGL_BIT) | (DATA_W'(1) << POLL_BIT);

   if (DATA_W < 2) begin : g_bad_w
      $error("stat_poll: DATA_W must be at least 2");
   end
   if (TGL_BIT < 0 || TGL_BIT >= DATA_W || POLL_BIT < 0 || POLL_BIT >= DATA_W) begin : g_bad_pos
      $error("stat_poll: status lanes must lie inside the data word");
   end
   if (TGL_BIT == POLL_BIT) begin : g_bad_same
      $error("stat_poll: toggle and polling lanes must differ");
   end

   logic     active;
   op_kind_e kind;
   logic     msb;
   logic     tgl;
   logic     poll;

   stat_poll_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (op_start),
      .kind_i   (op_kind),
      .msb_i    (wr_msb),
      .busy_i   (busy_in),
      .fail_i   (fail_in),
      .abort_i  (abort_in),
      .active_o (active),
      .kind_o   (kind),
      .msb_o    (msb),
      .done_o   (done_out)
   );

   stat_poll_toggle u_toggle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (op_start),
      .step_i  (rd_strobe && active),
      .tgl_o   (tgl)
   );

   assign poll = poll_level(kind, msb);

   stat_poll_mux #(
      .DATA_W   (DATA_W),
      .TGL_BIT  (TGL_BIT),
      .POLL_BIT (POLL_BIT),
      .REG_OUT  (REG_OUT)
   ) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_i     (rd_strobe),
      .status_i (active),
      .tgl_i    (tgl),
      .poll_i   (poll),
      .arr_i    (array_data),
      .dq_o     (dq_out),
      .oe_o     (dq_oe)
   );

   if (REG_OUT) begin : g_chk
      // R6
      status_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_strobe && active && !op_start |=> dq_oe == STAT_MASK && (dq_out & ~STAT_MASK) == '0);

      // R10
      data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_strobe && !active |=> dq_oe == '1 && dq_out == $past(array_data));

      // R5
      erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_strobe && active && kind == OP_ERASE |=> !dq_out[POLL_BIT]);

      // R2
      toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_strobe && active && !op_start |=> tgl != $past(tgl));
   end

endmodule

// File: tb/stat_poll_bench.sv
module stat_poll_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start = 1'b0;
   logic       op_kind = 1'b0;
   logic       wr_msb = 1'b0;
   logic       busy_in = 1'b0;
   logic       fail_in = 1'b0;
   logic       abort_in = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] array_data = 8'h00;
   logic [7:0] dq_out;
   logic [7:0] dq_oe;
   logic       done_out;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   stat_poll u_stat_poll (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_start   (op_start),
      .op_kind    (op_kind),
      .wr_msb     (wr_msb),
      .busy_in    (busy_in),
      .fail_in    (fail_in),
      .abort_in   (abort_in),
      .rd_strobe  (rd_strobe),
      .array_data (array_data),
      .dq_out     (dq_out),
      .dq_oe      (dq_oe),
      .done_out   (done_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_read(input logic [7:0] data);
      rd_strobe  = 1'b1;
      array_data = data;
      tick();
      rd_strobe  = 1'b0;
      array_data = ~data;
   endtask

   task automatic start_op(input logic kind, input logic msb);
      op_start = 1'b1;
      op_kind  = kind;
      wr_msb   = msb;
      busy_in  = 1'b1;
      tick();
      op_start = 1'b0;
      wr_msb   = ~msb;
   endtask

   task automatic pulse_abort();
      abort_in = 1'b1;
      tick();
      abort_in = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      tick();
      tick();
      // R1: outputs during reset
      check("R1 dq_out in reset", dq_out, 8'h00);
      check("R1 dq_oe in reset", dq_oe, 8'h00);
      check("R1 done in reset", {7'b0, done_out}, 8'h00);
      rst_n = 1'b1;
      tick();
      check("R1 dq_oe after reset", dq_oe, 8'h00);
      check("R1 done after reset", {7'b0, done_out}, 8'h00);

      for (int scen = 0; scen < 32; scen++) begin
         logic       kind;
         logic       msb;
         logic       endf;
         int         nrd;
         logic [7:0] base;
         logic [7:0] exp_word;
         int         cnt;
         kind = scen[0];
         msb  = scen[1];
         endf = scen[2];
         nrd  = (scen >> 3) + 1;
         base = 8'((scen * 37 + 5) & 8'hFF);

         // R10: idle read returns array data
         do_read(base);
         check("R10 idle data", dq_out, base);
         check("R10 idle oe", dq_oe, 8'hFF);

         start_op(kind, msb);
         cnt = 0;
         for (int i = 0; i < nrd; i++) begin
            int gap;
            gap = (i + scen) % 3;
            do_read(8'(base + 8'(i * 11)));
            exp_word = {(kind ? 1'b0 : ~msb), 1'(cnt % 2), 6'b0};
            if (i == 0)
               check("R2 R11 first status read", dq_out, exp_word);
            else
               check("R2 R3 status alternation", dq_out, exp_word);
            if (kind)
               check("R5 erase poll bit", {7'b0, dq_out[7]}, 8'h00);
            else
               check("R4 program poll bit", {7'b0, dq_out[7]}, {7'b0, ~msb});
            check("R6 status oe", dq_oe, 8'hC0);
            cnt++;
            for (int g = 0; g < gap; g++) tick();
            check("R9 held word", dq_out, exp_word);
            check("R9 held oe", dq_oe, 8'hC0);
         end

         busy_in = 1'b0;
         fail_in = endf;
         tick();
         if (!endf) begin
            check("R7 done pulse", {7'b0, done_out}, 8'h01);
            tick();
            check("R7 done ends", {7'b0, done_out}, 8'h00);
            do_read(8'(base ^ 8'h5A));
            check("R7 data after done", dq_out, 8'(base ^ 8'h5A));
            check("R7 oe after done", dq_oe, 8'hFF);
            do_read(8'(base ^ 8'h5A));
            check("R7 bit6 stable", {7'b0, dq_out[6]}, {7'b0, base[6] ^ 1'b1});
         end else begin
            check("R8 no done on fail", {7'b0, done_out}, 8'h00);
            tick();
            check("R8 no done later", {7'b0, done_out}, 8'h00);
            for (int j = 0; j < 2; j++) begin
               do_read(8'(base + 8'h33));
               exp_word = {(kind ? 1'b0 : ~msb), 1'(cnt % 2), 6'b0};
               check("R8 status after fail", dq_out, exp_word);
               check("R8 oe after fail", dq_oe, 8'hC0);
               cnt++;
            end
            fail_in = 1'b0;
            pulse_abort();
            do_read(8'(base + 8'h44));
            check("R8 data after abort", dq_out, 8'(base + 8'h44));
            check("R8 oe after abort", dq_oe, 8'hFF);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule